// File: doc/BRIEF.md
# Three-Wire-Plus-Select Serial EEPROM Responder

This block is a synthesizable stand-in for a small serial EEPROM of 64 words by 16 bits. A host drives a select pin, a serial clock and a serial data input. It reads answers back on a serial data output that comes with an output-enable flag. All four serial pins are sampled in the block's own system clock domain. A rising serial-clock edge is detected when the sampled clock goes from low to high between two system clock cycles.

An instruction opens with a single 1 bit. Zeros sent before that bit are skipped. The start bit is followed by a two-bit operation code and a six-bit word address, most significant bit first. Write-type instructions then take sixteen data bits, also most significant bit first. The operation code 00 is an extended group: its variant is chosen by the two top address bits. The block holds the storage array, a write-enable latch that gates every modifying instruction, and a 17-bit output shifter. That shifter sends a leading 0 followed by the addressed word.

The serial pins carry a bit-level protocol and not a word stream, so no valid/ready handshake is placed at the edge. Flow is paced entirely by the host's serial clock, and the responder never applies back-pressure.

Top module: `uwire_eeprom`

## Requirements
- R1: An instruction frame starts at the first rising serial-clock edge, while select is high, that samples a 1 on the data input. Zeros sampled before it are ignored. The next 8 rising edges sample the opcode (2 bits) and then the address, from bit 5 down to bit 0.
- R2: Opcode 10 reads the addressed word. After the edge that samples address bit 0, the data output shows 0. Each later rising serial-clock edge launches the next bit: D15 first and D0 last. The output enable is high during this phase.
- R3: Opcode 01 takes 16 further data bits, D15 first. With writes enabled, it stores them in the addressed word after the 16th bit.
- R4: Opcode 11 sets the addressed word to 16'hFFFF when writes are enabled.
- R5: Opcode 00 with address bits [5:4] = 11 sets the write-enable latch, and with [5:4] = 00 clears it. Address bits [3:0] are don't-care for the whole 00 group.
- R6: Opcode 00 with [5:4] = 10 sets every word to 16'hFFFF. Opcode 00 with [5:4] = 01 takes 16 data bits and writes that value to every word. Both require writes to be enabled.
- R7: Any of the four modifying instructions leaves the array unchanged while the write-enable latch is clear.
- R8: After reset the write-enable latch is clear, every word reads 16'hFFFF, and the data output and output enable are 0.
- R9: Dropping select aborts a partial instruction, with no change to the array, and the next frame again waits for a start bit. While select is low, the data output and output enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Chip select, high while an instruction is being exchanged |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the responder |
| sdo_o | output | 1 | Serial data out of the responder, 0 when not driving |
| sdo_oe_o | output | 1 | High while the responder is driving read data |

## Verification
The assertions assume that the serial pins are synchronous to the system clock, and that each serial-clock level lasts at least one system clock cycle so that every rising edge is seen exactly once. They also assume that select and data input change only while the serial clock is low. The bench holds each serial-clock phase for three system clocks, drives pins only on the falling system-clock edge, and raises or drops select only with the serial clock low. The random opcode, address and data choices therefore never break these timing rules.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    K_WRITE, K_ERASE, K_EWEN, K_EWDS, K_ERAL, K_WRAL
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_READ, S_DONE
  } state_e;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_EWEN = 2'b11;
  localparam logic [1:0] SUB_ERAL = 2'b10;
  localparam logic [1:0] SUB_WRAL = 2'b01;
endpackage

// File: rtl/uw_edge.sv
module uw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic rise_o
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_i;
  end

  assign rise_o = sclk_i & ~sclk_q;

  // R1: one detected edge per serial-clock high phase
  assert_single_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/uw_frame.sv
module uw_frame
  import uw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              rise_i,
  output logic              cmd_vld_o,
  output kind_e             kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              rd_load_o,
  output logic              sh_en_o,
  output logic              rd_active_o
);
  localparam int HDR_BITS = ADDR_W + 2;
  localparam int MAXB     = (DATA_W > HDR_BITS) ? DATA_W : HDR_BITS;
  localparam int CNT_W    = $clog2(MAXB + 1);

  state_e              state_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [HDR_BITS-2:0] hdr_q;
  logic [DATA_W-1:0]   dat_q;
  logic [ADDR_W-1:0]   addr_q;
  kind_e               kind_q;
  logic                cmd_vld_q, rd_load_q, sh_en_q;

  logic [HDR_BITS-1:0] hdr_full;
  logic [1:0]          op;
  logic [ADDR_W-1:0]   a_in;
  logic [1:0]          sub;
  logic [DATA_W-1:0]   data_full;
  logic                hdr_last, data_last;

  always_comb begin
    hdr_full  = {hdr_q, di_i};
    op        = hdr_full[HDR_BITS-1 -: 2];
    a_in      = hdr_full[ADDR_W-1:0];
    sub       = a_in[ADDR_W-1 -: 2];
    data_full = {dat_q[DATA_W-2:0], di_i};
    hdr_last  = (cnt_q == CNT_W'(HDR_BITS - 1));
    data_last = (cnt_q == CNT_W'(DATA_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      cnt_q     <= '0;
      hdr_q     <= '0;
      dat_q     <= '0;
      addr_q    <= '0;
      kind_q    <= K_EWDS;
      cmd_vld_q <= 1'b0;
      rd_load_q <= 1'b0;
      sh_en_q   <= 1'b0;
    end else begin
      cmd_vld_q <= 1'b0;
      rd_load_q <= 1'b0;
      sh_en_q   <= 1'b0;
      if (!cs_i) begin
        state_q <= S_IDLE;
        cnt_q   <= '0;
      end else if (rise_i) begin
        case (state_q)
          S_IDLE: begin
            if (di_i) begin
              state_q <= S_HDR;
              cnt_q   <= '0;
            end
          end
          S_HDR: begin
            hdr_q <= hdr_full[HDR_BITS-2:0];
            cnt_q <= cnt_q + 1'b1;
            if (hdr_last) begin
              cnt_q  <= '0;
              addr_q <= a_in;
              case (op)
                OP_READ: begin
                  state_q   <= S_READ;
                  rd_load_q <= 1'b1;
                end
                OP_WRITE: begin
                  kind_q  <= K_WRITE;
                  state_q <= S_DATA;
                end
                OP_ERASE: begin
                  kind_q    <= K_ERASE;
                  cmd_vld_q <= 1'b1;
                  state_q   <= S_DONE;
                end
                default: begin
                  case (sub)
                    SUB_EWEN: begin
                      kind_q    <= K_EWEN;
                      cmd_vld_q <= 1'b1;
                      state_q   <= S_DONE;
                    end
                    SUB_ERAL: begin
                      kind_q    <= K_ERAL;
                      cmd_vld_q <= 1'b1;
                      state_q   <= S_DONE;
                    end
                    SUB_WRAL: begin
                      kind_q  <= K_WRAL;
                      state_q <= S_DATA;
                    end
                    default: begin
                      kind_q    <= K_EWDS;
                      cmd_vld_q <= 1'b1;
                      state_q   <= S_DONE;
                    end
                  endcase
                end
              endcase
            end
          end
          S_DATA: begin
            dat_q <= data_full;
            cnt_q <= cnt_q + 1'b1;
            if (data_last) begin
              cnt_q     <= '0;
              cmd_vld_q <= 1'b1;
              state_q   <= S_DONE;
            end
          end
          S_READ:  sh_en_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign cmd_vld_o   = cmd_vld_q;
  assign kind_o      = kind_q;
  assign addr_o      = addr_q;
  assign data_o      = dat_q;
  assign rd_load_o   = rd_load_q;
  assign sh_en_o     = sh_en_q;
  assign rd_active_o = (state_q == S_READ);

  // R9: deselect returns the frame to waiting for a start bit, issuing nothing
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |=> (state_q == S_IDLE) && !cmd_vld_q && !rd_load_q);

  // R1: the bit counter stays inside the longest field
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(MAXB));

  // R1: no command can be issued without a serial-clock edge before it
  assert_cmd_after_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_i || !cs_i) |=> !cmd_vld_q && !rd_load_q);
endmodule

// File: rtl/uw_array.sv
module uw_array
  import uw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld_i,
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic                         wen_q;
  logic [DATA_W-1:0]            wr_val;
  logic                         wr_go, all_words, one_word;

  always_comb begin
    wr_go     = cmd_vld_i && wen_q;
    all_words = (kind_i == K_ERAL) || (kind_i == K_WRAL);
    one_word  = (kind_i == K_WRITE) || (kind_i == K_ERASE);
    wr_val    = ((kind_i == K_WRITE) || (kind_i == K_WRAL)) ? data_i : '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (cmd_vld_i) begin
      if (kind_i == K_EWEN)      wen_q <= 1'b1;
      else if (kind_i == K_EWDS) wen_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit;
    assign hit = wr_go && (all_words || (one_word && (addr_i == ADDR_W'(w))));
    always_ff @(posedge clk) begin
      if (!rst_n)   mem_q[w] <= '1;
      else if (hit) mem_q[w] <= wr_val;
    end
  end

  assign rdata_o = mem_q[addr_i];

  // R7: a cleared latch freezes the whole array
  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wen_q |=> $stable(mem_q));

  // R5: the disable variant always leaves the latch clear
  assert_ewds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && kind_i == K_EWDS) |=> !wen_q);

  // R6: an enabled erase-all leaves every word at all ones
  assert_eral_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && wen_q && kind_i == K_ERAL) |=> (mem_q == '1));

  // R3: an enabled single-word write lands at its address
  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && wen_q && kind_i == K_WRITE) |=> (mem_q[$past(addr_i)] == $past(data_i)));
endmodule

// File: rtl/uw_serial.sv
module uw_serial #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              bit_o
);
  logic [DATA_W:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_i) sh_q <= '0;
    else if (load_i)     sh_q <= {1'b0, word_i};
    else if (shift_i)    sh_q <= {sh_q[DATA_W-1:0], 1'b0};
  end

  assign bit_o = sh_q[DATA_W];

  // R2: the first bit presented after a read is loaded is the leading zero
  assert_dummy_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && cs_i) |=> !bit_o);

  // R9: with select low the shifter holds nothing to send
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_i && !load_i && !shift_i) |=> (sh_q == '0));
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uw_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              rise;
  logic              cmd_vld, rd_load, sh_en, rd_active, out_bit;
  kind_e             kind;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  uw_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sclk_i (sclk_i),
    .rise_o (rise)
  );

  uw_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_i        (sel_i),
    .di_i        (sdi_i),
    .rise_i      (rise),
    .cmd_vld_o   (cmd_vld),
    .kind_o      (kind),
    .addr_o      (addr),
    .data_o      (wdata),
    .rd_load_o   (rd_load),
    .sh_en_o     (sh_en),
    .rd_active_o (rd_active)
  );

  uw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_vld_i (cmd_vld),
    .kind_i    (kind),
    .addr_i    (addr),
    .data_i    (wdata),
    .rdata_o   (rdata)
  );

  uw_serial #(.DATA_W(DATA_W)) u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_i    (sel_i),
    .load_i  (rd_load),
    .shift_i (sh_en),
    .word_i  (rdata),
    .bit_o   (out_bit)
  );

  assign sdo_oe_o = sel_i & rd_active;
  assign sdo_o    = sdo_oe_o & out_bit;

  // R8/R9: the output is driven only while a read frame is active
  assert_drive_only_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_o |-> (sel_i && u_frame.rd_active_o));
endmodule

// File: tb/uwire_eeprom_test.sv
`timescale 1ns/1ps
module uwire_eeprom_test;
  localparam int HOLD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;

  int vectors = 0;
  int errors  = 0;
  logic [15:0] model [64];
  logic        wen_m;

  always #4 clk = ~clk;

  uwire_eeprom uut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_i(sclk),
    .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sk_bit(input logic b);
    sdi = b; sclk = 1'b0; waitc(HOLD);
    sclk = 1'b1; waitc(HOLD);
  endtask

  task automatic deselect();
    sclk = 1'b0; waitc(2);
    sel = 1'b0; sdi = 1'b0; waitc(2);
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
    sel = 1'b1; waitc(1);
    sk_bit(1'b1);
    for (int i = 1; i >= 0; i--) sk_bit(op[i]);
    for (int i = 5; i >= 0; i--) sk_bit(a[i]);
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [5:0] a,
                          input logic [15:0] d, input bit has_data);
    send_hdr(op, a);
    if (has_data) for (int i = 15; i >= 0; i--) sk_bit(d[i]);
    deselect();
  endtask

  // returns {dummy, D15..D0}
  task automatic do_read(input logic [5:0] a, output logic [16:0] got);
    send_hdr(2'b10, a);
    got[16] = sdo;
    for (int i = 15; i >= 0; i--) begin
      sk_bit(1'b0);
      got[i] = sdo;
    end
    deselect();
  endtask

  function automatic void model_apply(input logic [1:0] op, input logic [5:0] a,
                                      input logic [15:0] d);
    case (op)
      2'b01: if (wen_m) model[a] = d;
      2'b11: if (wen_m) model[a] = 16'hFFFF;
      2'b00: case (a[5:4])
        2'b11: wen_m = 1'b1;
        2'b00: wen_m = 1'b0;
        2'b10: if (wen_m) for (int k = 0; k < 64; k++) model[k] = 16'hFFFF;
        default: if (wen_m) for (int k = 0; k < 64; k++) model[k] = d;
      endcase
      default: ;
    endcase
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d);
    bit hd = (op == 2'b01) || (op == 2'b00 && a[5:4] == 2'b01);
    send_cmd(op, a, d, hd);
    model_apply(op, a, d);
  endtask

  task automatic read_chk(input string req, input logic [5:0] a);
    logic [16:0] got;
    do_read(a, got);
    chk(req, got, {1'b0, model[a]});
  endtask

  initial begin
    #(8ns * 190000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [16:0] got;
    for (int k = 0; k < 64; k++) model[k] = 16'hFFFF;
    wen_m = 1'b0;
    waitc(4);
    rst_n = 1'b1;
    waitc(2);

    // R8: reset state of the pins and the array
    chk("R8 pins", {15'd0, sdo_oe, sdo}, 17'd0);
    read_chk("R8 word0", 6'd0);
    read_chk("R8 word63", 6'd63);

    // R7: write before any enable is ignored
    run_cmd(2'b01, 6'd5, 16'h1234);
    read_chk("R7 locked write", 6'd5);

    // R5: enable with arbitrary low bits, then R3 write
    run_cmd(2'b00, 6'b11_0101, 16'h0);
    run_cmd(2'b01, 6'd5, 16'hA5C3);
    read_chk("R3 write", 6'd5);
    run_cmd(2'b01, 6'd62, 16'h8001);
    read_chk("R3 write edge bits", 6'd62);

    // R1: leading zeros before the start bit are skipped
    sel = 1'b1; waitc(1);
    sk_bit(1'b0); sk_bit(1'b0); sk_bit(1'b0);
    sk_bit(1'b1); sk_bit(1'b1); sk_bit(1'b0);
    for (int i = 5; i >= 0; i--) sk_bit(1'((6'd5 >> i) & 6'd1));
    got[16] = sdo;
    for (int i = 15; i >= 0; i--) begin sk_bit(1'b0); got[i] = sdo; end
    deselect();
    chk("R1 leading zeros", got, {1'b0, model[5]});

    // R4: erase
    run_cmd(2'b11, 6'd5, 16'h0);
    read_chk("R4 erase", 6'd5);

    // R6: write-all then erase-all
    run_cmd(2'b00, 6'b01_1110, 16'h5A5A);
    read_chk("R6 wral lo", 6'd0);
    read_chk("R6 wral hi", 6'd63);
    run_cmd(2'b00, 6'b10_0011, 16'h0);
    read_chk("R6 eral", 6'd17);

    // R9: abort a write mid-data
    run_cmd(2'b01, 6'd9, 16'h0F0F);
    send_hdr(2'b01, 6'd9);
    for (int i = 0; i < 8; i++) sk_bit(1'b0);
    deselect();
    read_chk("R9 aborted write", 6'd9);

    // R9: drop select in the middle of a read
    send_hdr(2'b10, 6'd9);
    sk_bit(1'b0); sk_bit(1'b0);
    deselect();
    chk("R9 quiet pins", {15'd0, sdo_oe, sdo}, 17'd0);
    read_chk("R9 next frame", 6'd9);

    // R5/R7: disable with arbitrary low bits blocks writes
    run_cmd(2'b00, 6'b00_1010, 16'h0);
    run_cmd(2'b01, 6'd9, 16'h7777);
    run_cmd(2'b00, 6'b10_0000, 16'h0);
    read_chk("R7 locked after disable", 6'd9);
    read_chk("R5 disable kept", 6'd30);

    // random mix (R2..R7)
    void'($urandom(32'h5EED_0017));
    for (int n = 0; n < 150; n++) begin
      int sel_op = $urandom_range(0, 9);
      logic [5:0]  a = 6'($urandom_range(0, 63));
      logic [15:0] d = 16'($urandom);
      case (sel_op)
        0, 1, 2, 3: read_chk("R2 random read", a);
        4: run_cmd(2'b01, a, d);
        5: run_cmd(2'b11, a, d);
        6: run_cmd(2'b00, {2'b11, a[3:0]}, d);
        7: run_cmd(2'b00, {2'b00, a[3:0]}, d);
        8: run_cmd(2'b00, {2'b01, a[3:0]}, d);
        default: if (a[0]) run_cmd(2'b00, {2'b10, a[3:0]}, d);
                 else      run_cmd(2'b01, a, d);
      endcase
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule